// File: doc/BRIEF.md
# Interleaved Multichannel Pulse Dispatcher

A single inductive converter produces one current pulse in every high-frequency period of 1 µs. This block shares that pulse stream among up to eight stimulation channels. At every period boundary it takes a snapshot of the channel-enable mask and picks the next enabled channel in round-robin order. It also latches that channel's duty value, its electrode pair and its polarity. For the whole of the next period it drives the converter's charge and deliver switch controls and the one-hot high-side and low-side electrode drives. At the last tick of the period it raises a per-channel strobe that marks the pulse as sent.

A period is `PERIOD_TICKS` ticks of the fine clock long. The charge interval opens at tick 0 and lasts for the channel's duty value, clamped to a safe maximum. After a dead gap the deliver interval runs until one dead tick before the period ends. If the zero-current comparator fires during the deliver interval, the deliver switch and the electrode drives open and stay open until the period ends. This gives discontinuous conduction with no reverse current. When n channels are enabled, each channel receives one pulse every n periods. When channels leave the mask, the channels that remain absorb their slots.

Top module: `pulse_dispatch`

## Requirements
- R1: While reset is held, and until the first period starts after reset is released, `sw_charge`, `sw_deliver`, `drv_high`, `drv_low` and `pulse_sent` are all zero.
- R2: In a served period, `sw_charge` is high in ticks 0 to on-1 and low otherwise. Here on = min(duty, PERIOD_TICKS-2*DEAD_TICKS-1), which is 47 with the defaults.
- R3: With on > 0 and no zero-current event, `sw_deliver` is high from tick on+DEAD_TICKS through tick PERIOD_TICKS-DEAD_TICKS-1 (ticks on+1 to 48 with the defaults) and low otherwise. It is never high together with `sw_charge`.
- R4: If `zero_cur` is high at a clock edge while the deliver interval is open, `sw_deliver` and both electrode drives are low from the next cycle until the period ends, even if `zero_cur` falls again. A `zero_cur` pulse outside the deliver interval has no effect.
- R5: Channels are served in ascending index order among the enabled ones, wrapping from the highest index to the lowest. The channel after the last served one is searched first. The first channel served after reset is the lowest enabled index.
- R6: The mask, duty, electrode and polarity inputs are sampled only at the clock edge that ends a period. A change inside a period does not alter that period's outputs.
- R7: A period that begins with an all-zero mask drives every switch and electrode output low and raises no strobe.
- R8: While `sw_deliver` is high, `drv_high` is one-hot at electrode A and `drv_low` is one-hot at electrode B when the channel's reverse bit is 0. The two are swapped when the bit is 1. Both are zero whenever `sw_deliver` is low.
- R9: `pulse_sent` is one-hot on the served channel during the last tick of its period and zero in every other tick.
- R10: A served channel with duty 0 keeps both switches open for the whole period, but it still consumes its slot and its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine tick clock; PERIOD_TICKS ticks make one pulse period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_enable | input | NUM_CH | Per-channel enable mask |
| chan_duty | input | NUM_CH*DUTY_W | Per-channel charge time in ticks, channel c at bits c*DUTY_W upward |
| chan_elec_a | input | NUM_CH*EL_W | Per-channel first electrode index |
| chan_elec_b | input | NUM_CH*EL_W | Per-channel second electrode index |
| chan_reverse | input | NUM_CH | Per-channel polarity: 0 drives A high-side, 1 drives B high-side |
| zero_cur | input | 1 | Zero-current comparator flag |
| sw_charge | output | 1 | Charge switches closed (source across inductor) |
| sw_deliver | output | 1 | Deliver switch closed (inductor into bridge) |
| drv_high | output | NUM_ELEC | One-hot high-side electrode drive |
| drv_low | output | NUM_ELEC | One-hot low-side electrode drive |
| pulse_sent | output | NUM_CH | Per-channel pulse-delivered strobe |

## Verification
The bound checker watches every cycle for the following: charge and deliver never overlap, and a dead gap lies on both sides of each charge interval. The charge run length never exceeds the clamped maximum. The deliver switch opens on the cycle after a zero-current event. The electrode drives stay one-hot and stay idle outside delivery, and the strobes stay one-hot. The bench scenarios alone can show the round-robin order, the slot takeover when channels leave, the boundary-only sampling of the configuration, the exact tick positions of each interval for clamped and zero duty, the polarity swap, and the idle periods when the mask is empty.

// File: rtl/disp_pkg.sv
package disp_pkg;

  // Window a tick falls into within one pulse period.
  typedef enum logic [1:0] {
    PH_CHARGE  = 2'd0,
    PH_GAP     = 2'd1,
    PH_DELIVER = 2'd2
  } phase_e;

  // Longest legal charge time that still leaves a dead tick before and after
  // the deliver window and at least one deliver tick.
  function automatic int unsigned on_limit(int unsigned period, int unsigned dead);
    return period - 2 * dead - 1;
  endfunction

  function automatic int unsigned clamp_u(int unsigned v, int unsigned lim);
    return (v > lim) ? lim : v;
  endfunction

endpackage

// File: rtl/disp_rst_sync.sv
module disp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/disp_rr_pick.sv
module disp_rr_pick #(
  parameter  int NUM_CH = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [CH_W-1:0]   last,
  output logic              found,
  output logic [CH_W-1:0]   pick
);

  // Search from the channel after 'last'; the smallest offset wins, so the
  // loop runs from the farthest offset down to the nearest.
  always_comb begin
    int idx;
    found = 1'b0;
    pick  = last;
    idx   = 0;
    for (int k = NUM_CH; k >= 1; k--) begin
      idx = (int'(last) + k) % NUM_CH;
      if (req[idx]) begin
        found = 1'b1;
        pick  = CH_W'(idx);
      end
    end
  end

endmodule

// File: rtl/disp_slot_timer.sv
module disp_slot_timer
  import disp_pkg::*;
#(
  parameter  int PERIOD_TICKS = 50,
  parameter  int DEAD_TICKS   = 1,
  localparam int TICK_W       = $clog2(PERIOD_TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] on_ticks,
  output logic              last_tick,
  output phase_e            phase
);

  logic [TICK_W-1:0] tick_q;
  logic [TICK_W-1:0] tick_d;

  assign last_tick = (int'(tick_q) == PERIOD_TICKS - 1);

  always_comb begin
    tick_d = last_tick ? '0 : tick_q + 1'b1;
  end

  // Reset parks the counter on the last tick so the first clock after reset
  // release opens a fresh period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= TICK_W'(PERIOD_TICKS - 1);
    else        tick_q <= tick_d;
  end

  always_comb begin
    int t;
    int on;
    t  = int'(tick_q);
    on = int'(on_ticks);
    if (t < on)
      phase = PH_CHARGE;
    else if ((on != 0) && (t >= on + DEAD_TICKS) && (t < PERIOD_TICKS - DEAD_TICKS))
      phase = PH_DELIVER;
    else
      phase = PH_GAP;
  end

endmodule

// File: rtl/disp_route_dec.sv
module disp_route_dec #(
  parameter  int NUM_ELEC = 16,
  localparam int EL_W     = (NUM_ELEC > 1) ? $clog2(NUM_ELEC) : 1
) (
  input  logic                en,
  input  logic [EL_W-1:0]     elec_hi,
  input  logic [EL_W-1:0]     elec_lo,
  output logic [NUM_ELEC-1:0] drv_high,
  output logic [NUM_ELEC-1:0] drv_low
);

  for (genvar e = 0; e < NUM_ELEC; e++) begin : g_elec
    assign drv_high[e] = en && (int'(elec_hi) == e);
    assign drv_low[e]  = en && (int'(elec_lo) == e);
  end

endmodule

// File: rtl/pulse_dispatch.sv
module pulse_dispatch
  import disp_pkg::*;
#(
  parameter  int NUM_CH       = 8,
  parameter  int NUM_ELEC     = 16,
  parameter  int DUTY_W       = 6,
  parameter  int PERIOD_TICKS = 50,
  parameter  int DEAD_TICKS   = 1,
  localparam int CH_W         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int EL_W         = (NUM_ELEC > 1) ? $clog2(NUM_ELEC) : 1,
  localparam int TICK_W       = $clog2(PERIOD_TICKS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        chan_enable,
  input  logic [NUM_CH*DUTY_W-1:0] chan_duty,
  input  logic [NUM_CH*EL_W-1:0]   chan_elec_a,
  input  logic [NUM_CH*EL_W-1:0]   chan_elec_b,
  input  logic [NUM_CH-1:0]        chan_reverse,
  input  logic                     zero_cur,
  output logic                     sw_charge,
  output logic                     sw_deliver,
  output logic [NUM_ELEC-1:0]      drv_high,
  output logic [NUM_ELEC-1:0]      drv_low,
  output logic [NUM_CH-1:0]        pulse_sent
);

  localparam int unsigned MAX_ON = on_limit(PERIOD_TICKS, DEAD_TICKS);

  logic rst_n_i;

  disp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  // Per-channel field views.
  logic [DUTY_W-1:0] duty_a [NUM_CH];
  logic [EL_W-1:0]   ea_a   [NUM_CH];
  logic [EL_W-1:0]   eb_a   [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_unpack
    assign duty_a[c] = chan_duty[c*DUTY_W +: DUTY_W];
    assign ea_a[c]   = chan_elec_a[c*EL_W +: EL_W];
    assign eb_a[c]   = chan_elec_b[c*EL_W +: EL_W];
  end

  // Slot state for the period in progress.
  logic              slot_vld_q, slot_vld_d;
  logic [CH_W-1:0]   slot_ch_q,  slot_ch_d;
  logic [TICK_W-1:0] slot_on_q,  slot_on_d;
  logic [EL_W-1:0]   slot_hi_q,  slot_hi_d;
  logic [EL_W-1:0]   slot_lo_q,  slot_lo_d;
  logic [CH_W-1:0]   last_q,     last_d;
  logic              zc_q,       zc_d;

  logic              last_tick;
  phase_e            phase;
  logic              rr_found;
  logic [CH_W-1:0]   rr_pick;
  logic              deliver_win;

  disp_rr_pick #(.NUM_CH(NUM_CH)) u_rr (
    .req   (chan_enable),
    .last  (last_q),
    .found (rr_found),
    .pick  (rr_pick)
  );

  disp_slot_timer #(
    .PERIOD_TICKS (PERIOD_TICKS),
    .DEAD_TICKS   (DEAD_TICKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .on_ticks  (slot_on_q),
    .last_tick (last_tick),
    .phase     (phase)
  );

  // Next-state: configuration is captured only at the period boundary.
  always_comb begin
    slot_vld_d = slot_vld_q;
    slot_ch_d  = slot_ch_q;
    slot_on_d  = slot_on_q;
    slot_hi_d  = slot_hi_q;
    slot_lo_d  = slot_lo_q;
    last_d     = last_q;
    if (last_tick) begin
      slot_vld_d = rr_found;
      if (rr_found) begin
        slot_ch_d = rr_pick;
        last_d    = rr_pick;
        slot_on_d = TICK_W'(clamp_u(32'(duty_a[rr_pick]), MAX_ON));
        if (chan_reverse[rr_pick]) begin
          slot_hi_d = eb_a[rr_pick];
          slot_lo_d = ea_a[rr_pick];
        end else begin
          slot_hi_d = ea_a[rr_pick];
          slot_lo_d = eb_a[rr_pick];
        end
      end
    end
  end

  // Zero-current latch: set inside the deliver window, cleared at the boundary.
  always_comb begin
    if (last_tick) zc_d = 1'b0;
    else           zc_d = zc_q | (deliver_win & zero_cur);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      slot_vld_q <= 1'b0;
      slot_ch_q  <= '0;
      slot_on_q  <= '0;
      slot_hi_q  <= '0;
      slot_lo_q  <= '0;
      last_q     <= CH_W'(NUM_CH - 1);
      zc_q       <= 1'b0;
    end else begin
      slot_vld_q <= slot_vld_d;
      slot_ch_q  <= slot_ch_d;
      slot_on_q  <= slot_on_d;
      slot_hi_q  <= slot_hi_d;
      slot_lo_q  <= slot_lo_d;
      last_q     <= last_d;
      zc_q       <= zc_d;
    end
  end

  assign deliver_win = slot_vld_q && (phase == PH_DELIVER);
  assign sw_charge   = slot_vld_q && (phase == PH_CHARGE);
  assign sw_deliver  = deliver_win && !zc_q;

  disp_route_dec #(.NUM_ELEC(NUM_ELEC)) u_route (
    .en       (sw_deliver),
    .elec_hi  (slot_hi_q),
    .elec_lo  (slot_lo_q),
    .drv_high (drv_high),
    .drv_low  (drv_low)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
    assign pulse_sent[c] = slot_vld_q && last_tick && (int'(slot_ch_q) == c);
  end

endmodule

// File: rtl/pulse_dispatch_chk.sv
module pulse_dispatch_chk #(
  parameter int NUM_CH       = 8,
  parameter int NUM_ELEC     = 16,
  parameter int PERIOD_TICKS = 50,
  parameter int DEAD_TICKS   = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                zero_cur,
  input logic                sw_charge,
  input logic                sw_deliver,
  input logic [NUM_ELEC-1:0] drv_high,
  input logic [NUM_ELEC-1:0] drv_low,
  input logic [NUM_CH-1:0]   pulse_sent
);

  localparam int MAX_ON = PERIOD_TICKS - 2 * DEAD_TICKS - 1;
  localparam int RUN_W  = $clog2(PERIOD_TICKS + 1) + 1;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run_q <= '0;
    else if (!sw_charge)            run_q <= '0;
    else if (run_q != {RUN_W{1'b1}}) run_q <= run_q + 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_charge && sw_deliver)); // R3

  AST_GAP_AFTER_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_charge) |-> !sw_deliver); // R3

  AST_GAP_BEFORE_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_charge) |-> !$past(sw_deliver)); // R3

  AST_CHARGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) <= MAX_ON); // R2

  AST_ZC_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_deliver && zero_cur) |=> !sw_deliver); // R4

  AST_DRV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_high) && $onehot0(drv_low)); // R8

  AST_DRV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_deliver |-> ((drv_high == '0) && (drv_low == '0))); // R8

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse_sent)); // R9

endmodule

bind pulse_dispatch pulse_dispatch_chk #(
  .NUM_CH       (NUM_CH),
  .NUM_ELEC     (NUM_ELEC),
  .PERIOD_TICKS (PERIOD_TICKS),
  .DEAD_TICKS   (DEAD_TICKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .zero_cur   (zero_cur),
  .sw_charge  (sw_charge),
  .sw_deliver (sw_deliver),
  .drv_high   (drv_high),
  .drv_low    (drv_low),
  .pulse_sent (pulse_sent)
);

// File: tb/tb_pulse_dispatch.sv
module tb_pulse_dispatch;

  localparam int NUM_CH   = 8;
  localparam int NUM_ELEC = 16;
  localparam int DUTY_W   = 6;
  localparam int P        = 50;
  localparam int DEAD     = 1;
  localparam int EL_W     = 4;
  localparam int MAX_ON   = P - 2 * DEAD - 1;

  logic clk;
  logic rst_n;
  logic [NUM_CH-1:0] mask;
  logic [DUTY_W-1:0] duty [NUM_CH];
  logic [EL_W-1:0]   ea   [NUM_CH];
  logic [EL_W-1:0]   eb   [NUM_CH];
  logic              rev  [NUM_CH];
  logic              zc;

  logic [NUM_CH*DUTY_W-1:0] duty_f;
  logic [NUM_CH*EL_W-1:0]   ea_f, eb_f;
  logic [NUM_CH-1:0]        rev_f;

  logic                sw_charge, sw_deliver;
  logic [NUM_ELEC-1:0] drv_high, drv_low;
  logic [NUM_CH-1:0]   pulse_sent;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      duty_f[c*DUTY_W +: DUTY_W] = duty[c];
      ea_f[c*EL_W +: EL_W]       = ea[c];
      eb_f[c*EL_W +: EL_W]       = eb[c];
      rev_f[c]                   = rev[c];
    end
  end

  pulse_dispatch #(
    .NUM_CH(NUM_CH), .NUM_ELEC(NUM_ELEC), .DUTY_W(DUTY_W),
    .PERIOD_TICKS(P), .DEAD_TICKS(DEAD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .chan_enable(mask), .chan_duty(duty_f),
    .chan_elec_a(ea_f), .chan_elec_b(eb_f), .chan_reverse(rev_f),
    .zero_cur(zc), .sw_charge(sw_charge), .sw_deliver(sw_deliver),
    .drv_high(drv_high), .drv_low(drv_low), .pulse_sent(pulse_sent)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks;
  int errors;
  int exp_last;
  bit finished;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int rr_next(input logic [NUM_CH-1:0] m, input int last);
    for (int k = 1; k <= NUM_CH; k++) begin
      int idx;
      idx = (last + k) % NUM_CH;
      if (m[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic check_quiet(input string tag);
    chk(tag, "sw_charge", 32'(sw_charge), 32'd0);
    chk(tag, "sw_deliver", 32'(sw_deliver), 32'd0);
    chk(tag, "drv_high", 32'(drv_high), 32'd0);
    chk(tag, "drv_low", 32'(drv_low), 32'd0);
    chk(tag, "pulse_sent", 32'(pulse_sent), 32'd0);
  endtask

  // Runs one full period; entered just before the boundary edge.
  task automatic do_period(input int zc_at, input bit mid_chg,
                           input logic [NUM_CH-1:0] mid_mask);
    int c, on, hi, lo, dwin_lo, dwin_hi;
    bit zc_hit;
    c = rr_next(mask, exp_last);
    on = 0; hi = 0; lo = 0;
    if (c >= 0) begin
      exp_last = c;
      on = (int'(duty[c]) > MAX_ON) ? MAX_ON : int'(duty[c]);
      hi = rev[c] ? int'(eb[c]) : int'(ea[c]);
      lo = rev[c] ? int'(ea[c]) : int'(eb[c]);
    end
    dwin_lo = on + DEAD;
    dwin_hi = P - DEAD - 1;
    zc_hit = (c >= 0) && (zc_at >= 0) && (on != 0) && (zc_at >= dwin_lo) && (zc_at <= dwin_hi);
    for (int t = 0; t < P; t++) begin
      bit e_chg, e_del;
      logic [31:0] e_hi, e_lo, e_done;
      string tc, td;
      @(negedge clk);
      if (c < 0) begin
        check_quiet("R7");
      end else begin
        e_chg = (t < on);
        e_del = (on != 0) && (t >= dwin_lo) && (t <= dwin_hi) && !(zc_hit && t > zc_at);
        e_hi = e_del ? (32'd1 << hi) : 32'd0;
        e_lo = e_del ? (32'd1 << lo) : 32'd0;
        e_done = (t == P - 1) ? (32'd1 << c) : 32'd0;
        tc = (on == 0) ? "R10" : (mid_chg ? "R6" : "R2");
        td = (zc_at >= 0) ? "R4" : ((on == 0) ? "R10" : "R3");
        chk(tc, "sw_charge", 32'(sw_charge), 32'(e_chg));
        chk(td, "sw_deliver", 32'(sw_deliver), 32'(e_del));
        chk("R8", "drv_high", 32'(drv_high), e_hi);
        chk("R8", "drv_low", 32'(drv_low), e_lo);
        chk("R9", "pulse_sent", 32'(pulse_sent), e_done);
        if (t == P - 1) begin
          int idx;
          idx = -1;
          for (int k = 0; k < NUM_CH; k++) if (pulse_sent[k]) idx = k;
          chk("R5", "served channel", 32'(idx), 32'(c));
        end
      end
      if (t == zc_at) zc = 1'b1;
      if (t == zc_at + 1) zc = 1'b0;
      if (mid_chg && t == 0) begin
        mask = mid_mask;
        duty[c < 0 ? 0 : c] = 6'd3;
      end
    end
    zc = 1'b0;
  endtask

  initial begin
    finished = 1'b0;
    #(20 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    checks = 0; errors = 0;
    zc = 1'b0; rst_n = 1'b0; mask = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      duty[c] = 6'd8; ea[c] = EL_W'(c); eb[c] = EL_W'(15 - c); rev[c] = 1'b0;
    end
    mask = 8'hFF;
    repeat (3) begin
      @(negedge clk);
      check_quiet("R1");
    end
    rst_n = 1'b1;
    exp_last = NUM_CH - 1;
    @(negedge clk); check_quiet("R1");
    @(negedge clk); check_quiet("R1");

    // Lone channel receives every pulse; then polarity swap.
    mask = 8'b0000_1000; duty[3] = 6'd10; ea[3] = 4'd2; eb[3] = 4'd9;
    repeat (3) do_period(-1, 1'b0, '0);
    rev[3] = 1'b1;
    do_period(-1, 1'b0, '0);

    // All channels, distinct duty and routing.
    for (int c = 0; c < NUM_CH; c++) begin
      duty[c] = 6'(c * 7 + 1); rev[c] = c[0];
    end
    mask = 8'hFF;
    repeat (16) do_period(-1, 1'b0, '0);

    // Sparse mask with wrap-around.
    mask = 8'b0101_0010;
    repeat (6) do_period(-1, 1'b0, '0);

    // Duty clamp and zero duty.
    mask = 8'b0000_0001;
    duty[0] = 6'd63; do_period(-1, 1'b0, '0);
    duty[0] = 6'd47; do_period(-1, 1'b0, '0);
    duty[0] = 6'd46; do_period(-1, 1'b0, '0);
    duty[0] = 6'd0;  do_period(-1, 1'b0, '0);
    duty[0] = 6'd1;  do_period(-1, 1'b0, '0);

    // Zero-current cutoff inside and outside the deliver window.
    duty[0] = 6'd20;
    do_period(30, 1'b0, '0);
    do_period(21, 1'b0, '0);
    do_period(10, 1'b0, '0);
    do_period(48, 1'b0, '0);

    // Empty mask.
    mask = '0;
    repeat (3) do_period(-1, 1'b0, '0);

    // Mid-period change does not affect the running period.
    mask = 8'b0000_0100; duty[2] = 6'd30;
    do_period(-1, 1'b1, 8'b0010_0000);
    do_period(-1, 1'b0, '0);

    // Channel leaves; survivor takes every slot.
    mask = 8'b0000_0011;
    repeat (2) do_period(-1, 1'b0, '0);
    mask = 8'b0000_0001;
    repeat (3) do_period(-1, 1'b0, '0);

    // Constrained random.
    repeat (200) begin
      int ch, zat;
      bit mc;
      if ($urandom_range(0, 3) == 0) mask = NUM_CH'($urandom_range(0, 255));
      ch = $urandom_range(0, NUM_CH - 1);
      duty[ch] = DUTY_W'($urandom_range(0, 63));
      ea[ch] = EL_W'($urandom_range(0, 15));
      eb[ch] = EL_W'($urandom_range(0, 15));
      rev[ch] = 1'($urandom_range(0, 1));
      zat = ($urandom_range(0, 1) == 1) ? $urandom_range(0, P - 2) : -1;
      mc = ($urandom_range(0, 7) == 0);
      do_period(zat, mc, NUM_CH'($urandom_range(0, 255)));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule